// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave end of a two-wire serial memory, built around the read side. It runs on a fast system clock and oversamples the SCL and SDA bus lines. It sees START, repeated START and STOP, and it drives SDA low through an open-drain output enable. A select byte carries a fixed family code, three bits matched against the chip-select pins, and a direction bit. A write-direction select byte followed by two address bytes loads an internal pointer. After a repeated START, a read-direction select byte then streams bytes from that pointer. A read-direction select byte sent on its own streams from wherever the pointer was left.

The pointer steps after every byte sent and wraps at the end of the array. Output continues for as long as the master acknowledges. A write-cycle busy input makes the slave refuse its select byte, so the master can poll until the memory is ready. The array is read-only, and its content is a fixed arithmetic pattern of the location. Bus traffic is the only data path, so the block has no streaming handshake at its edge.

Top module: `i2c_rom_reader`

## Requirements
- R1: A select byte is acknowledged only when its bits 7:4 are 1010, its bits 3:1 equal `chip_sel` and `wcycle_busy` is low. Bit 0 is the direction, 1 for read. The acknowledge is SDA held low during the ninth clock. On a mismatch the slave leaves SDA released until the next START.
- R2: `sda_oe` changes only while SCL is low, apart from the moment a START or STOP is seen.
- R3: A random read runs as follows.
  - The master sends a write-direction select byte, then the address high byte, then the low byte. The slave acknowledges each of the three.
  - These bytes set the pointer to the 16-bit address modulo 2^ADDR_W.
  - A repeated START follows, with a read-direction select byte whose upper seven bits are the same. The slave acknowledges it and returns the byte at the loaded address.
- R4: After the address bytes, a read-direction select byte whose upper seven bits differ from those of the address-loading select byte is not acknowledged. This holds even when the new byte matches the current `chip_sel`.
- R5: A read-direction select byte sent directly after a START, with no address phase, returns the byte at the current pointer.
- R6: The pointer advances by one on the acknowledge clock of every byte sent. It wraps from location 2^ADDR_W-1 to 0, and it keeps its value across transactions.
- R7: While the master acknowledges each data byte (SDA low on the ninth clock), the next byte follows. After a byte the master does not acknowledge, the slave releases SDA and sends nothing until a START.
- R8: While `wcycle_busy` is high, no select byte is acknowledged. Once it is low, the same select byte is acknowledged.
- R9: The byte at location a is ((a*PAT_MUL + PAT_ADD) mod 256) XOR (a>>8 mod 256). Bits are sent most significant first.
- R10: A START or STOP in the middle of a byte abandons the transfer and leaves the pointer unchanged. After a START, the slave takes the next byte as a select byte.
- R11: After reset, SDA is released and the pointer is 0.
- R12: A data byte sent after the two address bytes, with no repeated START, is not acknowledged. It leaves the array and the pointer as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| chip_sel | input | 3 | Device address pins matched against select bits 3:1 |
| wcycle_busy | input | 1 | High while an internal write cycle is running |

## Verification
The bench builds the block with ADDR_W = 6, which gives 64 locations, and with PAT_MUL = 37 and PAT_ADD = 90. With this small array, a random read of every single location fits in the run. A short sequential burst starting near the top crosses the wrap back to zero. The odd multiplier gives every location a distinct byte, so a pointer that is off by one shows up as a wrong value. The remaining cases run on the same configuration: busy polling, chip-select mismatches, mid-byte aborts and trailing write bytes. Each of them is followed by a current-address read, which shows that the pointer kept its value.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // waiting for START
    ST_DEV,   // shifting in select byte
    ST_AHI,   // shifting in address high byte
    ST_ALO,   // shifting in address low byte
    ST_ACK,   // slave holds acknowledge
    ST_TX,    // slave shifts a data byte out
    ST_MACK   // master acknowledge slot
  } rd_state_e;

  localparam logic [3:0] FAMILY_CODE = 4'b1010;
  localparam int         BYTE_BITS   = 8;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_lvl  = scl_q[STAGES-1];
  assign sda_lvl  = sda_q[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_p;
  assign scl_fall = ~scl_lvl & scl_p;
  assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2cr_pattern_rom.sv
module i2cr_pattern_rom #(
  parameter int ADDR_W  = 15,
  parameter int PAT_MUL = 37,
  parameter int PAT_ADD = 90
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  logic [15:0] a16;

  always_comb begin
    a16  = 16'(addr);
    data = 8'(a16 * 16'(PAT_MUL) + 16'(PAT_ADD)) ^ a16[15:8];
  end
endmodule

// File: rtl/i2cr_addr_ctr.sv
module i2cr_addr_ctr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_rom_reader.sv
module i2c_rom_reader
  import i2cr_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAT_MUL     = 37,
  parameter int PAT_ADD     = 90,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] chip_sel,
  input  logic       wcycle_busy
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_BITS - 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  rd_state_e st, ret_st;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0] sh, addr_hi;
  logic [6:0] saved7;
  logic rnd_pend, mack_ok;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] rom_data;
  logic byte_in, dev_hit, dev_ok, ptr_load, ptr_step;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cr_pattern_rom #(.ADDR_W(ADDR_W), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_rom (
    .addr(ptr), .data(rom_data)
  );

  i2cr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load),
    .load_val(ADDR_W'({addr_hi, sh})), .step(ptr_step), .ptr(ptr)
  );

  // a received byte is complete on the falling edge after its eighth bit
  assign byte_in  = scl_fall && (bitcnt == LAST_RX);
  assign dev_hit  = (sh[7:4] == FAMILY_CODE) && (sh[3:1] == chip_sel) && !wcycle_busy;
  assign dev_ok   = dev_hit && !(rnd_pend && sh[0] && (sh[7:1] != saved7));
  assign ptr_load = (st == ST_ALO) && byte_in;
  assign ptr_step = (st == ST_MACK) && scl_rise;

  always_comb begin
    sda_oe = (st == ST_ACK) || ((st == ST_TX) && !sh[7]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ret_st   <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      addr_hi  <= '0;
      saved7   <= '0;
      rnd_pend <= 1'b0;
      mack_ok  <= 1'b0;
    end else if (stop_ev) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      rnd_pend <= 1'b0;
    end else if (start_ev) begin
      st     <= ST_DEV;
      bitcnt <= '0;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise && bitcnt != LAST_RX) begin
            sh     <= {sh[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_in) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              rnd_pend <= 1'b0;
              if (dev_ok) begin
                st     <= ST_ACK;
                ret_st <= sh[0] ? ST_TX : ST_AHI;
                saved7 <= sh[7:1];
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_AHI) begin
              addr_hi <= sh;
              st      <= ST_ACK;
              ret_st  <= ST_ALO;
            end else begin
              st       <= ST_ACK;
              ret_st   <= ST_IDLE;
              rnd_pend <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st     <= ret_st;
            bitcnt <= '0;
            if (ret_st == ST_TX) sh <= rom_data;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            sh <= {sh[6:0], 1'b1};
            if (bitcnt == LAST_TX) begin
              st     <= ST_MACK;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= !sda_lvl;
          end else if (scl_fall) begin
            if (mack_ok) begin
              st <= ST_TX;
              sh <= rom_data;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: the data line is left alone while the clock is high
  a_r2_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && !start_ev && !stop_ev) |=> $stable(sda_oe));

  // R8: busy write cycle refuses the select byte
  a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DEV) && byte_in && wcycle_busy) |=> !sda_oe);

  // R4: repeated select byte must repeat the upper seven bits
  a_r4_rs_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DEV) && byte_in && rnd_pend && sh[0] && (sh[7:1] != saved7)) |=> !sda_oe);

  // R6: one pointer step per master acknowledge slot, wrapping
  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_MACK) && scl_rise) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  // R7: master not acknowledging ends the burst with SDA released
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_MACK) && scl_fall && !mack_ok) |=> ((st == ST_IDLE) && !sda_oe));

  // R10: START always restarts select-byte reception
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> ((st == ST_DEV) && !sda_oe));
endmodule

// File: tb/sim_i2c_rom_reader.sv
module sim_i2c_rom_reader;
  localparam int AW = 6, MUL = 37, ADD = 90, H = 8, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] cs = 3'b101;
  logic sda_oe, sda_line;
  int n_tests = 0, n_fail = 0;
  int exp_ptr = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  i2c_rom_reader #(.ADDR_W(AW), .PAT_MUL(MUL), .PAT_ADD(ADD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_sel(cs), .wcycle_busy(busy)
  );

  function automatic logic [7:0] pat(int a);
    int v;
    v = a * MUL + ADD;
    return 8'(v) ^ 8'(a >> 8);
  endfunction

  function automatic logic [7:0] dsel(logic [2:0] c, logic rw);
    return {4'b1010, c, rw};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; scl = 1'b1; wc(H);
    sda_m = 1'b0; wc(H);
    scl = 1'b0; wc(2);
  endtask

  task automatic b_rstart();
    sda_m = 1'b1; wc(H);
    scl = 1'b1; wc(H);
    sda_m = 1'b0; wc(H);
    scl = 1'b0; wc(2);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wc(H);
    scl = 1'b1; wc(H);
    sda_m = 1'b1; wc(H);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wc(H);
      scl = 1'b1; wc(H);
      scl = 1'b0; wc(2);
    end
  endtask

  task automatic get_ack(output bit ack);
    sda_m = 1'b1; wc(H);
    scl = 1'b1; wc(H / 2);
    ack = (sda_line == 1'b0);
    wc(H / 2);
    scl = 1'b0; wc(2);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    get_ack(ack);
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] b, output bit stable);
    logic v;
    b = '0; stable = 1'b1; sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wc(H);
      scl = 1'b1; wc(H / 2);
      v = sda_line; b[i] = v;
      wc(H / 2 - 1);
      if (sda_line != v) stable = 1'b0;
      scl = 1'b0; wc(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wc(H);
    scl = 1'b1; wc(H);
    scl = 1'b0; wc(2);
    sda_m = 1'b1;
  endtask

  // reads n bytes from the expected pointer, acknowledging all but the last
  task automatic rd_burst(int n, string req);
    logic [7:0] b;
    bit st;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b, st);
      chk(b == pat(exp_ptr), req, b, pat(exp_ptr));
      chk(st, "R2 data stable while SCL high", st, 1);
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
  endtask

  task automatic sel_expect(logic [7:0] d, bit want, string req);
    bit a;
    send_byte(d, a);
    chk(a == want, req, a, want);
  endtask

  task automatic load_addr(logic [7:0] hi, logic [7:0] lo, string req);
    b_start();
    sel_expect(dsel(cs, 1'b0), 1'b1, req);
    sel_expect(hi, 1'b1, req);
    sel_expect(lo, 1'b1, req);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    wc(150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    logic [7:0] b;
    bit st;
    wc(5); rst_n = 1'b1; wc(5);
    chk(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);

    // R11 R5: current read right after reset starts at location 0
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R1 read select acknowledged");
    rd_burst(1, "R5 R11 current read from pointer 0");
    b_stop();
    // R6: pointer moved on by one
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R1 read select acknowledged");
    rd_burst(1, "R6 current read after one byte");
    b_stop();

    // R3 R9: random read of every location, high address bits ignored
    for (int a = 0; a < DEPTH; a++) begin
      load_addr(8'(a * 7 + 3), 8'(a + DEPTH * (a % 4)), "R3 address phase acknowledged");
      b_rstart();
      sel_expect(dsel(cs, 1'b1), 1'b1, "R3 repeated read select acknowledged");
      exp_ptr = a;
      rd_burst(1, "R3 R9 random read content");
      b_stop();
    end

    // R7 R6: sequential burst across the wrap
    load_addr(8'h00, 8'(DEPTH - 4), "R3 address phase acknowledged");
    b_rstart();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R3 repeated read select acknowledged");
    exp_ptr = DEPTH - 4;
    rd_burst(8, "R7 R6 sequential burst with wrap");
    recv_byte(1'b0, b, st);
    chk(b == 8'hFF, "R7 silent after master withheld acknowledge", b, 8'hFF);
    b_stop();
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R1 read select acknowledged");
    rd_burst(1, "R6 pointer kept after burst");
    b_stop();

    // R8: busy polling
    busy = 1'b1;
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b0, "R8 no acknowledge while busy");
    b_stop();
    busy = 1'b0;
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R8 acknowledge once idle");
    rd_burst(1, "R8 pointer unchanged by refused poll");
    b_stop();

    // R1: select mismatches stay silent
    b_start();
    sel_expect(dsel(3'b011, 1'b1), 1'b0, "R1 chip-select mismatch");
    recv_byte(1'b0, b, st);
    chk(b == 8'hFF, "R1 silent after mismatch", b, 8'hFF);
    b_stop();
    b_start();
    sel_expect({4'b1011, cs, 1'b1}, 1'b0, "R1 family code mismatch");
    b_stop();

    // R4: repeated select with different upper bits
    load_addr(8'h00, 8'd20, "R3 address phase acknowledged");
    cs = 3'b110;
    b_rstart();
    sel_expect(dsel(cs, 1'b1), 1'b0, "R4 changed select refused");
    b_stop();
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R1 read select acknowledged");
    exp_ptr = 20;
    rd_burst(1, "R4 loaded pointer retained");
    b_stop();

    // R12: trailing data byte is refused and changes nothing
    load_addr(8'h00, 8'd40, "R3 address phase acknowledged");
    sel_expect(8'h00, 1'b0, "R12 data byte not acknowledged");
    b_stop();
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R1 read select acknowledged");
    exp_ptr = 40;
    rd_burst(1, "R12 array and pointer unchanged");
    b_stop();

    // R10: START in the middle of the low address byte
    b_start();
    sel_expect(dsel(cs, 1'b0), 1'b1, "R1 write select acknowledged");
    sel_expect(8'h00, 1'b1, "R3 address high acknowledged");
    send_bits(8'd9, 4);
    b_rstart();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R10 select after aborting START");
    rd_burst(1, "R10 pointer kept after START abort");
    b_stop();
    // R10: STOP in the middle of a byte
    b_start();
    sel_expect(dsel(cs, 1'b0), 1'b1, "R1 write select acknowledged");
    send_bits(8'hAA, 3);
    b_stop();
    b_start();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R10 select after aborting STOP");
    rd_burst(1, "R10 pointer kept after STOP abort");
    b_stop();
    // R10: START inside the select byte itself
    b_start();
    send_bits(8'hA0, 5);
    b_rstart();
    sel_expect(dsel(cs, 1'b1), 1'b1, "R10 select after partial select");
    rd_burst(1, "R10 read after partial select");
    b_stop();

    done = 1'b1;
    finish_up();
  end
endmodule